// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation period of one fan. The fan's sense line enters through a two-stage synchroniser and a debounce filter of selectable length. An edge selector then picks falling edges, rising edges or every edge. A counter runs on a prescaled clock and counts ticks between two consecutive qualifying edges. Each count is loaded into a value register, and system software turns that value into a speed.

All configuration comes from one 32-bit control word, and all results are reported in one 32-bit status word. Each new measurement is compared against a programmable threshold. The compare can test for "above" or, when inverted, for "below". A hit sets a sticky interrupt status bit, which a one-cycle clear strobe removes. When no qualifying edge arrives, the counter saturates. A stalled fan therefore reads as the all-ones value. A full-measurement flag shows that the value register holds a complete edge-to-edge interval taken since the channel was last enabled.

Top module: `tach_channel`

## Requirements
- R1: Once reset has been released, `stat_word` reads zero and `irq` is low while `fan_in` is held low.
- R2: The edge mode sits in control bits [25:24]. Code 0 measures from one falling edge to the next falling edge. Code 1 measures from one rising edge to the next rising edge. The value in status bits [19:0] equals the number of counting ticks in the interval.
- R3: Edge-mode codes 2 and 3 measure between any two consecutive edges, whatever their polarity.
- R4: The counting tick is the clock divided by 4^n, where n is control bits [23:20]. Any n above 11 acts as 11.
- R5: The debounce code sits in control bits [27:26]. Codes 0, 1 and 2 require the new level to stay stable for 3, 2 and 1 ticks respectively before the filtered level follows it. Code 3 applies no filtering. A pulse shorter than the required length leaves the filtered level unchanged.
- R6: Status bit 22 shows the synchronised raw input level. Status bit 23 shows the filtered level.
- R7: Status bit 20 (full measurement) stays clear after the first qualifying edge that follows enable. It sets on the second qualifying edge.
- R8: Status bit 21 pulses high for exactly one cycle each time the value register loads. The value register never changes at any other time.
- R9: With no qualifying edge, the running count saturates at all ones. At the moment of saturation, the all-ones value is loaded into the value register, where it stays.
- R10: A new value sets interrupt status bit 31 when the value is strictly greater than threshold control bits [19:0]. When control bit 30 is set, the condition becomes strictly less than the threshold. Values that fail the compare leave bit 31 unchanged.
- R11: Output `irq` equals status bit 31 gated by control bit 31. A one-cycle `irq_clr` clears bit 31. If a new hit arrives in the same cycle as the clear, the set wins.
- R12: Control bit 28 enables the channel. While it is clear, the running count, the full flag and the update flag are all held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctrl_word | input | 32 | Control word: enable, debounce, edge mode, divider, threshold, compare sense, interrupt enable |
| irq_clr | input | 1 | One-cycle strobe that clears the interrupt status |
| fan_in | input | 1 | Raw fan sense signal, asynchronous |
| stat_word | output | 32 | Status word: value, full and update flags, raw and filtered levels, interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `ctrl_word` is quasi-static. It changes only while the channel is disabled, or while the fan line is idle. Under that assumption, a measurement never mixes two divider or mode settings. The stimulus respects this rule: it reprograms only after the fan has stopped and the channel has been switched off. It toggles `fan_in` on falling clock edges, with high and low times longer than the debounce window, except where a short pulse is the point of the test. The saturation property is exercised on a second instance with a narrow counter, so the all-ones state is reached within the run.

// File: rtl/tach_pkg.sv
package tach_pkg;
  // control word field positions
  localparam int CB_IER    = 31;
  localparam int CB_INV    = 30;
  localparam int CB_EN     = 28;
  localparam int CB_DEB_HI = 27;
  localparam int CB_DEB_LO = 26;
  localparam int CB_EDG_HI = 25;
  localparam int CB_EDG_LO = 24;
  localparam int CB_DIV_HI = 23;
  localparam int CB_DIV_LO = 20;
  localparam int FIELD_W   = 20;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_ANY  = 2'd2,
    EDGE_ANY2 = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int MAX_N = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] div_sel,
  output logic       tick
);
  localparam int PW = 2 * MAX_N;

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] mask;
  logic [3:0]    n_eff;

  always_comb begin
    n_eff = (div_sel > 4'(MAX_N)) ? 4'(MAX_N) : div_sel;
    mask  = ~({PW{1'b1}} << {n_eff, 1'b0});
    tick  = en && ((cnt_q & mask) == mask);
    cnt_d = en ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tach_debounce.sv
module tach_debounce (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       pin,
  input  logic [1:0] code,
  output logic       sync_o,
  output logic       deb_o
);
  logic       s1_q, s2_q;
  logic       deb_q, deb_d;
  logic [1:0] cnt_q, cnt_d;
  logic [1:0] need;

  always_comb begin
    need  = 2'd3 - code;
    deb_d = deb_q;
    cnt_d = cnt_q;
    if (!en || need == 2'd0) begin
      deb_d = s2_q;
      cnt_d = 2'd0;
    end else if (s2_q == deb_q) begin
      cnt_d = 2'd0;
    end else if (tick) begin
      if (cnt_q == need - 2'd1) begin
        deb_d = s2_q;
        cnt_d = 2'd0;
      end else begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      deb_q <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      s1_q  <= pin;
      s2_q  <= s1_q;
      deb_q <= deb_d;
      cnt_q <= cnt_d;
    end
  end

  assign sync_o = s2_q;
  assign deb_o  = deb_q;
endmodule

// File: rtl/tach_period_cnt.sv
module tach_period_cnt
  import tach_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             deb,
  input  edge_mode_e       mode,
  output logic             qual,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] val_o,
  output logic             full_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] val_q, val_d;
  logic             armed_q, armed_d;
  logic             full_q, full_d;
  logic             upd_q, upd_d;
  logic             rise, fall;

  always_comb begin
    rise = deb & ~prev_q;
    fall = ~deb & prev_q;
    case (mode)
      EDGE_FALL: qual = en & fall;
      EDGE_RISE: qual = en & rise;
      default:   qual = en & (rise | fall);
    endcase
    cnt_inc = (cnt_q == CMAX) ? CMAX : cnt_q + CNT_W'(tick);

    cnt_d   = cnt_inc;
    val_d   = val_q;
    armed_d = armed_q;
    full_d  = full_q;
    upd_d   = 1'b0;
    if (!en) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      full_d  = 1'b0;
    end else if (qual) begin
      cnt_d   = '0;
      armed_d = 1'b1;
      if (armed_q) begin
        val_d  = cnt_inc;
        full_d = 1'b1;
        upd_d  = 1'b1;
      end
    end else if (tick && cnt_q == CMAX - 1'b1) begin
      val_d = CMAX;
      upd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      val_q   <= '0;
      armed_q <= 1'b0;
      full_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      prev_q  <= deb;
      cnt_q   <= cnt_d;
      val_q   <= val_d;
      armed_q <= armed_d;
      full_q  <= full_d;
      upd_q   <= upd_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign val_o  = val_q;
  assign full_o = full_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/tach_channel.sv
module tach_channel
  import tach_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int MAX_N = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctrl_word,
  input  logic        irq_clr,
  input  logic        fan_in,
  output logic [31:0] stat_word,
  output logic        irq
);
  logic             rs1_q, rst_q_n;
  logic             en, inv, ier;
  logic [1:0]       deb_code;
  edge_mode_e       mode;
  logic [3:0]       div_sel;
  logic [FIELD_W-1:0] thr;
  logic             ctrl_unused;
  logic             tick, sync_lvl, deb_lvl, qual;
  logic [CNT_W-1:0] run_cnt, val;
  logic             full, upd;
  logic [FIELD_W-1:0] val_ext;
  logic             hit;
  logic             irq_sts_q, irq_sts_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_q_n <= rs1_q;
    end
  end

  always_comb begin
    en          = ctrl_word[CB_EN];
    inv         = ctrl_word[CB_INV];
    ier         = ctrl_word[CB_IER];
    deb_code    = ctrl_word[CB_DEB_HI:CB_DEB_LO];
    mode        = edge_mode_e'(ctrl_word[CB_EDG_HI:CB_EDG_LO]);
    div_sel     = ctrl_word[CB_DIV_HI:CB_DIV_LO];
    thr         = ctrl_word[FIELD_W-1:0];
    ctrl_unused = ctrl_word[29];
  end

  tach_prescaler #(.MAX_N(MAX_N)) u_pre (
    .clk(clk), .rst_n(rst_q_n), .en(en), .div_sel(div_sel), .tick(tick)
  );

  tach_debounce u_deb (
    .clk(clk), .rst_n(rst_q_n), .en(en), .tick(tick), .pin(fan_in),
    .code(deb_code), .sync_o(sync_lvl), .deb_o(deb_lvl)
  );

  tach_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .en(en), .tick(tick), .deb(deb_lvl),
    .mode(mode), .qual(qual), .cnt_o(run_cnt), .val_o(val),
    .full_o(full), .upd_o(upd)
  );

  always_comb begin
    val_ext   = FIELD_W'(val);
    hit       = inv ? (val_ext < thr) : (val_ext > thr);
    irq_sts_d = irq_sts_q;
    if (irq_clr)    irq_sts_d = 1'b0;
    if (upd && hit) irq_sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) irq_sts_q <= 1'b0;
    else          irq_sts_q <= irq_sts_d;
  end

  assign stat_word = {irq_sts_q, 7'd0, deb_lvl, sync_lvl, upd, full, val_ext};
  assign irq       = irq_sts_q & ier;
endmodule

// File: rtl/tach_channel_chk.sv
module tach_channel_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             qual,
  input logic             upd,
  input logic             full,
  input logic [CNT_W-1:0] val,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_sts
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R12
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!full && !upd && cnt == '0));

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == CMAX && !qual) |=> cnt == CMAX);

  // R8
  val_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(val));

  // R7
  full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> upd);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts) |-> $past(upd));
endmodule

bind tach_channel tach_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .en(en), .qual(qual), .upd(upd),
  .full(full), .val(val), .cnt(run_cnt), .irq_sts(irq_sts_q)
);

// File: tb/sim_tach_channel.sv
module sim_tach_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl, ctrl1;
  logic        irq_clr, fan, fan1;
  logic [31:0] stat, stat1;
  logic        irq, irq1;
  int          n_chk = 0, n_bad = 0, upd_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tach_channel u0 (.clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .irq_clr(irq_clr),
                   .fan_in(fan), .stat_word(stat), .irq(irq));
  tach_channel #(.CNT_W(10)) u1 (.clk(clk), .rst_n(rst_n), .ctrl_word(ctrl1),
                   .irq_clr(1'b0), .fan_in(fan1), .stat_word(stat1), .irq(irq1));

  always @(negedge clk) if (stat[21]) upd_seen++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input int mode, input int deb,
                                     input int dv, input int thr, input bit inv, input bit ier);
    logic [31:0] w;
    w = 32'(thr) & 32'hFFFFF;
    w[23:20] = 4'(dv);
    w[25:24] = 2'(mode);
    w[27:26] = 2'(deb);
    w[28] = en; w[30] = inv; w[31] = ier;
    return w;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] w);
    @(negedge clk); fan = 1'b0; ctrl = 32'd0; cyc(10);
    ctrl = w; cyc(10);
  endtask

  task automatic run_fan(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      fan = 1'b1; cyc(hi);
      fan = 1'b0; cyc(lo);
    end
  endtask

  task automatic t_reset;
    chk(stat, 32'd0, "R1 status after reset");
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
  endtask

  task automatic t_modes;
    setup(mk(1, 0, 3, 0, 0, 0, 0)); run_fan(30, 50, 5); cyc(20);
    chk({12'd0, stat[19:0]}, 32'd80, "R2 fall-to-fall value");
    setup(mk(1, 1, 3, 0, 0, 0, 0)); run_fan(30, 50, 5); cyc(20);
    chk({12'd0, stat[19:0]}, 32'd80, "R2 rise-to-rise value");
    setup(mk(1, 2, 0, 0, 0, 0, 0)); run_fan(40, 40, 4); cyc(5);
    chk({12'd0, stat[19:0]}, 32'd40, "R3 any-edge value");
    setup(mk(1, 3, 3, 0, 0, 0, 0)); run_fan(25, 25, 4); cyc(5);
    chk({12'd0, stat[19:0]}, 32'd25, "R3 code 3 any-edge value");
  endtask

  task automatic t_div;
    setup(mk(1, 0, 3, 1, 0, 0, 0)); run_fan(200, 200, 4); cyc(20);
    chk({12'd0, stat[19:0]}, 32'd100, "R4 divide by 4");
    setup(mk(1, 0, 1, 2, 0, 0, 0)); run_fan(160, 160, 4); cyc(20);
    chk({12'd0, stat[19:0]}, 32'd20, "R4 divide by 16");
  endtask

  task automatic t_debounce;
    setup(mk(1, 0, 0, 0, 0, 0, 0));
    fan = 1'b1; cyc(2); fan = 1'b0; cyc(8);
    chk({31'd0, stat[23]}, 32'd0, "R5 short pulse ignored");
    fan = 1'b1; cyc(2);
    chk({31'd0, stat[22]}, 32'd1, "R6 raw level after sync");
    cyc(2);
    chk({31'd0, stat[23]}, 32'd0, "R5 code0 not yet after 4");
    cyc(1);
    chk({31'd0, stat[23]}, 32'd1, "R5 code0 accepted after 5");
    chk({31'd0, stat[22]}, 32'd1, "R6 raw level high");
    setup(mk(1, 0, 1, 0, 0, 0, 0));
    fan = 1'b1; cyc(3);
    chk({31'd0, stat[23]}, 32'd0, "R5 code1 not yet after 3");
    cyc(1);
    chk({31'd0, stat[23]}, 32'd1, "R5 code1 accepted after 4");
    setup(mk(1, 0, 3, 0, 0, 0, 0));
    fan = 1'b1; cyc(3);
    chk({31'd0, stat[23]}, 32'd1, "R5 code3 follows at once");
    fan = 1'b0; cyc(5);
  endtask

  task automatic t_full_upd;
    setup(mk(1, 0, 3, 0, 0, 0, 0));
    upd_seen = 0;
    run_fan(30, 50, 1); cyc(5);
    chk({31'd0, stat[20]}, 32'd0, "R7 one edge not full");
    run_fan(30, 50, 1); cyc(5);
    chk({31'd0, stat[20]}, 32'd1, "R7 second edge full");
    setup(mk(1, 0, 3, 0, 0, 0, 0));
    upd_seen = 0;
    run_fan(30, 50, 5); cyc(20);
    chk(32'(upd_seen), 32'd4, "R8 one update per measurement");
    ctrl[28] = 1'b0; cyc(2);
    chk({30'd0, stat[21:20]}, 32'd0, "R12 disable clears flags");
    ctrl[28] = 1'b1; cyc(5);
    run_fan(30, 50, 1); cyc(5);
    chk({31'd0, stat[20]}, 32'd0, "R12 re-enable needs two edges");
  endtask

  task automatic t_irq;
    setup(mk(1, 0, 3, 0, 70, 0, 1));
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(2);
    run_fan(30, 50, 3); cyc(10);
    chk({stat[31], 30'd0, irq}, 32'h8000_0001, "R10 above threshold sets");
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(2);
    chk({stat[31], 30'd0, irq}, 32'd0, "R11 clear strobe");
    setup(mk(1, 0, 3, 0, 70, 1, 1));
    run_fan(30, 50, 3); cyc(10);
    chk({31'd0, stat[31]}, 32'd0, "R10 inverse not below ignored");
    setup(mk(1, 0, 3, 0, 90, 1, 1));
    run_fan(30, 50, 3); cyc(10);
    chk({31'd0, stat[31]}, 32'd1, "R10 inverse below sets");
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    setup(mk(1, 0, 3, 0, 70, 0, 0));
    run_fan(30, 50, 3); cyc(10);
    chk({stat[31], 30'd0, irq}, 32'h8000_0000, "R11 irq gated by enable bit");
  endtask

  task automatic t_sat;
    @(negedge clk); ctrl1 = mk(1, 0, 3, 0, 0, 0, 0);
    cyc(1100);
    chk({12'd0, stat1[19:0]}, 32'd1023, "R9 stalled reads max");
    chk({31'd0, stat1[20]}, 32'd0, "R9 stall not full");
    cyc(200);
    chk({12'd0, stat1[19:0]}, 32'd1023, "R9 max holds");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl = 32'd0; ctrl1 = 32'd0; irq_clr = 1'b0; fan = 1'b0; fan1 = 1'b0;
    cyc(3); rst_n = 1'b1; cyc(4);
    t_reset;
    t_modes;
    t_div;
    t_debounce;
    t_full_upd;
    t_irq;
    t_sat;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule